// File: doc/BRIEF.md
# Pattern Memory Access Controller

This block owns a 4096-word, 14-bit pattern memory and decides, cycle by cycle, who may use it: a register-bus host that loads and inspects patterns, or the waveform playback path that reads them out. The host sees the memory as a 4096-word window at addresses 0x6000 to 0x6FFF of a 16-bit address space. Each 14-bit word is carried left-justified in a 16-bit host word.

A 4-bit control/status register at address 0x1E sets the mode. Bit 0 is run, bit 2 is memory access and bit 3 is buffer read. Bit 1 is a spare that is stored and read back. The value 0x04 opens the memory for host writes, and 0x0C opens it for host reads. Any value with memory access set blocks playback. The run bit only reaches playback after a write of any data to the commit register at address 0x1D.

A mode state machine is derived from the register contents. IDLE means nothing is enabled. PLAY means run is committed and memory access is clear. LOAD means the register holds 0x04. DUMP means the register holds 0x0C. HOLD means memory access is set with any other value. After each status or commit write, the next state is chosen with this priority: to LOAD if the register becomes 0x04; else to DUMP if it becomes 0x0C; else to HOLD if memory access is set; else to PLAY if run is committed; else to IDLE. Any state can move to any other by this rule. Playback uses the memory only in PLAY.

Top module: `patmem_arbiter`

## Requirements
- R1: After reset the status register and committed run are zero, the mode is IDLE, and host_rvalid, host_rdata, pb_valid and pb_data are all zero.
- R2: A host write to 0x1E stores host_wdata[3:0] in the control/status register. host_wdata[15:4] is ignored. A read of 0x1E returns the stored value zero-extended to 16 bits.
- R3: A host write of any data to 0x1D copies the status run bit (bit 0) into the committed run. Playback reads are serviced only while committed run is 1 and memory access (bit 2) is 0.
- R4: Only addresses 0x6000 to 0x6FFF reach the memory, with the word index host_addr[11:0]. Writes to any address other than the window, 0x1E and 0x1D change nothing, and reads of those addresses return zero.
- R5: A host write to the window updates the memory only while the status register holds exactly 0x04. Otherwise the write is ignored.
- R6: A host read of the window returns memory data only while the status register holds exactly 0x0C. Otherwise it returns zero.
- R7: A window write stores host_wdata[15:2]. A window read returns the stored word in bits [15:2] with bits [1:0] zero.
- R8: While memory access (bit 2) is set, a playback request yields pb_valid = 0 and pb_data = 0.
- R9: Once memory access is cleared and committed run is still 1, playback requests are serviced again without another commit.
- R10: Every host read request (host_en=1, host_wr=0) gives host_rvalid=1 with its data in the next cycle. A playback request serviced in PLAY gives pb_valid=1 and the word at pb_addr in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host request strobe for this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response, one cycle after the request |
| pb_en | input | 1 | Playback read request |
| pb_addr | input | 12 | Playback word index |
| pb_data | output | 14 | Playback word, zero when not valid |
| pb_valid | output | 1 | Playback response, one cycle after the request |

## Verification
The embedded properties assume that the host presents at most one request per cycle and that host_addr is stable while host_en is high. They also assume the playback source may request at any time, including during host access. The mutual-exclusion property depends on the mode machine alone; it does not rely on the playback source staying quiet. The stimulus drives one host operation and one optional playback request per cycle, both set up half a cycle before the edge. It reads back only window words that were first loaded under LOAD, so every expected word is defined.

// File: rtl/patmem_pkg.sv
package patmem_pkg;

    localparam int STAT_W    = 4;
    localparam int RUN_BIT   = 0;
    localparam int MEM_BIT   = 2;
    localparam logic [STAT_W-1:0] LOAD_CODE = 4'h4;
    localparam logic [STAT_W-1:0] DUMP_CODE = 4'hC;

    typedef enum logic [2:0] {
        MODE_IDLE,
        MODE_PLAY,
        MODE_LOAD,
        MODE_DUMP,
        MODE_HOLD
    } mode_e;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_MEM,
        RSEL_STAT
    } rsel_e;

endpackage

// File: rtl/patmem_ram.sv
module patmem_ram #(
    parameter int WORD_W = 14,
    parameter int DEPTH  = 4096,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
        if (re) begin
            rdata <= cells[idx];
        end
    end

endmodule

// File: rtl/patmem_mode_fsm.sv
module patmem_mode_fsm
    import patmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              commit_we,
    output logic [STAT_W-1:0] stat_q,
    output logic              run_live,
    output logic              load_ok,
    output logic              dump_ok,
    output logic              play_ok
);

    mode_e             mode_q;
    mode_e             mode_d;
    logic [STAT_W-1:0] stat_d;
    logic              run_d;

    // next-state selection, highest priority first
    always_comb begin
        stat_d = stat_we   ? stat_wdata      : stat_q;
        run_d  = commit_we ? stat_q[RUN_BIT] : run_live;
        if (stat_d == LOAD_CODE) begin
            mode_d = MODE_LOAD;
        end else if (stat_d == DUMP_CODE) begin
            mode_d = MODE_DUMP;
        end else if (stat_d[MEM_BIT]) begin
            mode_d = MODE_HOLD;
        end else if (run_d) begin
            mode_d = MODE_PLAY;
        end else begin
            mode_d = MODE_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= '0;
            run_live <= 1'b0;
            mode_q   <= MODE_IDLE;
        end else begin
            stat_q   <= stat_d;
            run_live <= run_d;
            mode_q   <= mode_d;
        end
    end

    // per-state grants
    always_comb begin
        load_ok = 1'b0;
        dump_ok = 1'b0;
        play_ok = 1'b0;
        unique case (mode_q)
            MODE_IDLE: ;
            MODE_PLAY: play_ok = 1'b1;
            MODE_LOAD: load_ok = 1'b1;
            MODE_DUMP: dump_ok = 1'b1;
            MODE_HOLD: ;
            default:   ;
        endcase
    end

    p_commit_copies_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |=> (run_live == $past(stat_q[RUN_BIT])));

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_ok, dump_ok, play_ok}));

endmodule

// File: rtl/patmem_host_if.sv
module patmem_host_if
    import patmem_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 16,
    parameter int              WORD_W      = 14,
    parameter int              DEPTH       = 4096,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h6000,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h001E,
    parameter logic [ADDR_W-1:0] COMMIT_ADDR = 16'h001D,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PAD_W = DATA_W - WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              load_ok,
    input  logic              dump_ok,
    input  logic [STAT_W-1:0] stat_q,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [IDX_W-1:0]  ram_idx,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              stat_we,
    output logic [STAT_W-1:0] stat_wdata,
    output logic              commit_we,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);

    logic              in_win;
    logic              hit_stat;
    logic              hit_commit;
    logic              do_wr;
    logic              do_rd;
    rsel_e             rsel_d;
    rsel_e             rsel_q;
    logic [STAT_W-1:0] rstat_q;

    always_comb begin
        in_win     = host_addr[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W];
        hit_stat   = host_addr == STAT_ADDR;
        hit_commit = host_addr == COMMIT_ADDR;
        do_wr      = host_en && host_wr;
        do_rd      = host_en && !host_wr;
        ram_we     = do_wr && in_win && load_ok;
        ram_re     = do_rd && in_win && dump_ok;
        ram_idx    = host_addr[IDX_W-1:0];
        ram_wdata  = host_wdata[DATA_W-1:PAD_W];
        stat_we    = do_wr && hit_stat;
        stat_wdata = host_wdata[STAT_W-1:0];
        commit_we  = do_wr && hit_commit;
        if (ram_re) begin
            rsel_d = RSEL_MEM;
        end else if (do_rd && hit_stat) begin
            rsel_d = RSEL_STAT;
        end else begin
            rsel_d = RSEL_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            rsel_q      <= RSEL_NONE;
            rstat_q     <= '0;
        end else begin
            host_rvalid <= do_rd;
            rsel_q      <= rsel_d;
            rstat_q     <= stat_q;
        end
    end

    always_comb begin
        unique case (rsel_q)
            RSEL_MEM:  host_rdata = {ram_rdata, {PAD_W{1'b0}}};
            RSEL_STAT: host_rdata = {{(DATA_W-STAT_W){1'b0}}, rstat_q};
            default:   host_rdata = '0;
        endcase
    end

    p_read_response_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !host_wr) |=> host_rvalid);

    p_no_stray_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rvalid |-> (host_rdata == '0));

endmodule

// File: rtl/patmem_arbiter.sv
module patmem_arbiter
    import patmem_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 16,
    parameter int              WORD_W      = 14,
    parameter int              DEPTH       = 4096,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h6000,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h001E,
    parameter logic [ADDR_W-1:0] COMMIT_ADDR = 16'h001D,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              pb_en,
    input  logic [IDX_W-1:0]  pb_addr,
    output logic [WORD_W-1:0] pb_data,
    output logic              pb_valid
);

    logic              h_we;
    logic              h_re;
    logic [IDX_W-1:0]  h_idx;
    logic [WORD_W-1:0] h_wdata;
    logic              stat_we;
    logic [STAT_W-1:0] stat_wdata;
    logic              commit_we;
    logic [STAT_W-1:0] stat_q;
    logic              run_live;
    logic              load_ok;
    logic              dump_ok;
    logic              play_ok;
    logic              pb_rd;
    logic              ram_re;
    logic [IDX_W-1:0]  ram_idx;
    logic [WORD_W-1:0] ram_rdata;
    logic              pb_valid_q;

    patmem_mode_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .commit_we  (commit_we),
        .stat_q     (stat_q),
        .run_live   (run_live),
        .load_ok    (load_ok),
        .dump_ok    (dump_ok),
        .play_ok    (play_ok)
    );

    patmem_host_if #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WORD_W      (WORD_W),
        .DEPTH       (DEPTH),
        .WIN_BASE    (WIN_BASE),
        .STAT_ADDR   (STAT_ADDR),
        .COMMIT_ADDR (COMMIT_ADDR)
    ) i_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_en     (host_en),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .load_ok     (load_ok),
        .dump_ok     (dump_ok),
        .stat_q      (stat_q),
        .ram_rdata   (ram_rdata),
        .ram_we      (h_we),
        .ram_re      (h_re),
        .ram_idx     (h_idx),
        .ram_wdata   (h_wdata),
        .stat_we     (stat_we),
        .stat_wdata  (stat_wdata),
        .commit_we   (commit_we),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    // single memory port: the host owns it outside PLAY, playback inside
    always_comb begin
        pb_rd   = pb_en && play_ok;
        ram_re  = h_re || pb_rd;
        ram_idx = (h_we || h_re) ? h_idx : pb_addr;
    end

    patmem_ram #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) i_ram (
        .clk   (clk),
        .we    (h_we),
        .re    (ram_re),
        .idx   (ram_idx),
        .wdata (h_wdata),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_valid_q <= 1'b0;
        end else begin
            pb_valid_q <= pb_rd;
        end
    end

    always_comb begin
        pb_valid = pb_valid_q;
        pb_data  = pb_valid_q ? ram_rdata : '0;
    end

    p_port_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((h_we || h_re) && pb_rd));

    p_write_needs_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        h_we |-> (stat_q == LOAD_CODE));

    p_read_needs_dump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        h_re |-> (stat_q == DUMP_CODE));

    p_playback_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[MEM_BIT] |=> !pb_valid);

    p_playback_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_live |=> !pb_valid);

endmodule

// File: tb/test_patmem_arbiter.sv
module test_patmem_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_en;
    logic        host_wr;
    logic [15:0] host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        pb_en;
    logic [11:0] pb_addr;
    logic [13:0] pb_data;
    logic        pb_valid;

    always #4 clk = ~clk;

    patmem_arbiter i_patmem_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_en     (host_en),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .pb_en       (pb_en),
        .pb_addr     (pb_addr),
        .pb_data     (pb_data),
        .pb_valid    (pb_valid)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string tag_ovr = "";
    string pb_ovr = "";

    logic [13:0] m_mem [4096];
    logic [3:0]  m_stat;
    bit          m_run;

    // 1 PLAY, 2 LOAD, 3 DUMP, 4 HOLD, 0 IDLE
    function automatic int mode_of(logic [3:0] s, bit r);
        if (s == 4'h4) return 2;
        if (s == 4'hC) return 3;
        if (s[2])      return 4;
        if (r)         return 1;
        return 0;
    endfunction

    function automatic bit in_window(logic [15:0] a);
        return a[15:12] == 4'h6;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit he, bit hw, logic [15:0] ha, logic [15:0] hd,
                        bit pe, logic [11:0] pa);
        int          md;
        logic [15:0] e_rd;
        string       rtag;
        bit          e_pv;
        logic [13:0] e_pd;
        string       ptag;
        @(negedge clk);
        host_en = he; host_wr = hw; host_addr = ha; host_wdata = hd;
        pb_en = pe; pb_addr = pa;
        md = mode_of(m_stat, m_run);
        e_rd = '0;
        rtag = "R4";
        if (in_window(ha)) begin
            if (md == 3) begin
                e_rd = {m_mem[ha[11:0]], 2'b00};
                rtag = "R7";
            end else begin
                rtag = "R6";
            end
        end else if (ha == 16'h001E) begin
            e_rd = {12'h000, m_stat};
            rtag = "R2";
        end
        if (tag_ovr != "") rtag = tag_ovr;
        e_pv = pe && (md == 1);
        e_pd = e_pv ? m_mem[pa] : 14'h0;
        ptag = m_stat[2] ? "R8" : "R3";
        if (pb_ovr != "") ptag = pb_ovr;
        @(posedge clk);
        #1;
        chk("R10 rvalid", 32'(host_rvalid), 32'(he && !hw));
        if (he && !hw) chk(rtag, 32'(host_rdata), 32'(e_rd));
        chk({ptag, " pb_valid"}, 32'(pb_valid), 32'(e_pv));
        chk({ptag, " pb_data"}, 32'(pb_data), 32'(e_pd));
        if (he && hw) begin
            if (ha == 16'h001E)      m_stat = hd[3:0];
            else if (ha == 16'h001D) m_run = m_stat[0];
            else if (in_window(ha) && md == 2) m_mem[ha[11:0]] = hd[15:2];
        end
        host_en = 1'b0;
        pb_en = 1'b0;
    endtask

    function automatic logic [15:0] pick_win();
        int i;
        i = int'($urandom % 17);
        return (i == 16) ? 16'h6FFF : (16'h6000 + 16'(i));
    endfunction

    function automatic logic [11:0] pick_pb();
        int i;
        i = int'($urandom % 17);
        return (i == 16) ? 12'hFFF : 12'(i);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog act=running exp=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0]  codes [7];
        logic [15:0] outs [4];
        logic [15:0] keep0;
        void'($urandom(32'd20240611));
        codes = '{4'h4, 4'hC, 4'h0, 4'h1, 4'h5, 4'hD, 4'h2};
        outs  = '{16'h5FFF, 16'h7000, 16'hE123, 16'h0000};
        rst_n = 1'b0;
        host_en = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        pb_en = 1'b0; pb_addr = '0;
        m_stat = '0; m_run = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values at the ports
        chk("R1 rvalid", 32'(host_rvalid), 0);
        chk("R1 rdata", 32'(host_rdata), 0);
        chk("R1 pb_valid", 32'(pb_valid), 0);
        chk("R1 pb_data", 32'(pb_data), 0);
        rst_n = 1'b1;
        tag_ovr = "R1"; step(1, 0, 16'h001E, 0, 1, 12'h0); tag_ovr = "";

        // R2: upper bits of the status write are dropped
        step(1, 1, 16'h001E, 16'hFFF4, 0, 0);
        step(1, 0, 16'h001E, 0, 0, 0);

        // load the window under LOAD, low two bits set to exercise R7
        for (int i = 0; i < 17; i++) begin
            step(1, 1, (i == 16) ? 16'h6FFF : 16'h6000 + 16'(i),
                 16'($urandom), 0, 0);
        end
        // R4: out-of-window writes change nothing
        step(1, 1, 16'h7000, 16'hFFFF, 0, 0);
        step(1, 1, 16'h5FFF, 16'hFFFF, 0, 0);
        // R6: window read while in LOAD returns zero
        step(1, 0, 16'h6003, 0, 0, 0);
        step(1, 0, 16'h7000, 0, 0, 0);

        step(1, 1, 16'h001E, 16'h000C, 0, 0);
        for (int i = 0; i < 17; i++) begin
            step(1, 0, (i == 16) ? 16'h6FFF : 16'h6000 + 16'(i), 0, 0, 0);
        end
        // R5: write in DUMP is ignored, read back shows old word
        keep0 = {m_mem[0], 2'b00};
        step(1, 1, 16'h6000, 16'hAAAA, 0, 0);
        tag_ovr = "R5"; step(1, 0, 16'h6000, 0, 0, 0); tag_ovr = "";
        chk("R5 word kept", 32'({m_mem[0], 2'b00}), 32'(keep0));

        // R3: run pending without commit gives no playback
        step(1, 1, 16'h001E, 16'h0001, 0, 0);
        pb_ovr = "R3"; step(0, 0, 0, 0, 1, 12'h3);
        step(1, 1, 16'h001D, 16'h0000, 0, 0);
        step(0, 0, 0, 0, 1, 12'h3);
        step(0, 0, 0, 0, 1, 12'hFFF);
        pb_ovr = "";
        // R8: memory access with run pending blocks playback (HOLD)
        step(1, 1, 16'h001E, 16'h0005, 0, 0);
        pb_ovr = "R8"; step(0, 0, 0, 0, 1, 12'h3); pb_ovr = "";
        // R6: 0x0D is not the read code
        step(1, 1, 16'h001E, 16'h000D, 0, 0);
        tag_ovr = "R6"; step(1, 0, 16'h6001, 0, 1, 12'h1); tag_ovr = "";
        // R9: clearing memory access restores playback
        step(1, 1, 16'h001E, 16'h0001, 0, 0);
        pb_ovr = "R9"; step(0, 0, 0, 0, 1, 12'h5); pb_ovr = "";

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int          op;
            logic [15:0] ra;
            op = int'($urandom % 16);
            ra = pick_win();
            if (op < 2) begin
                step(1, 1, 16'h001E, {12'(($urandom)), codes[$urandom % 7]},
                     $urandom % 2 == 0, pick_pb());
            end else if (op == 2) begin
                step(1, 1, 16'h001D, 16'($urandom), 1, pick_pb());
            end else if (op < 9) begin
                step(1, 1, ra, 16'($urandom), $urandom % 2 == 0, pick_pb());
            end else if (op < 14) begin
                step(1, 0, ra, 0, $urandom % 2 == 0, pick_pb());
            end else if (op == 14) begin
                step(1, $urandom % 2 == 1, outs[$urandom % 4], 16'($urandom),
                     1, pick_pb());
            end else begin
                step(0, 0, 0, 0, 1, pick_pb());
            end
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule